// File: doc/BRIEF.md
# Dual-Pointer Audio Delay Controller

This block turns an external asynchronous SRAM into a circular sample buffer that delays an audio stream. It has two address counters, one for writing and one for reading. The clock cycles alternate between a write slot and a read slot. In each slot, the matching counter drives the single shared SRAM address bus. An incoming sample strobe queues one write. A read tick queues one read. Because the two strobes are independent, the input and output rates can differ, and varying the tick rate modulates the delay.

The delay value is captured in the first clock cycle after reset. The read side stays parked at address zero until that many samples have been written. From then on, each read returns samples in the order they were written. A read that finds no unread data returns zero and leaves the read counter where it is. A write that arrives when the buffer already holds a full depth of unread samples is still performed. It overwrites the oldest sample and raises a sticky overrun flag.

Top module: `audio_delay_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first stimulus, `smp_valid_o`, `overrun_o` and `sram_we_o` are 0.
- R2: SRAM accesses alternate. The cycle phase after reset is a write slot, the next is a read slot, and so on. A write (`sram_ce_o`=1, `sram_we_o`=1) never occurs in two consecutive cycles, and neither does a read (`sram_ce_o`=1, `sram_we_o`=0).
- R3: Each accepted input sample is written exactly once. The write uses `sram_wdata_o` equal to the sample, at an address that starts at 0 after reset and increments by one per write, modulo 2^ADDR_W.
- R4: `delay_i` is sampled in the first cycle after reset. Read ticks served before that many samples have been written return 0 and leave the read address at 0. The first read served after that returns the first sample written.
- R5: The read address starts at 0 and advances by one per successful read. Reads return samples in write order.
- R6: A read tick served when no unread sample exists returns 0 and leaves the read address unchanged (underrun).
- R7: A write made while 2^ADDR_W unread samples are buffered is still performed. It discards the oldest unread sample, and `overrun_o` goes to 1 and stays at 1 until reset.
- R8: Each read tick yields exactly one single-cycle `smp_valid_o` pulse. The pulse comes one cycle after the read slot that serves the tick, and that slot is the first read slot after the tick is registered.
- R9: Writes and reads proceed at independent rates. Any interleaving of sample strobes and read ticks preserves R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | DATA_W | Input sample |
| smp_valid_i | input | 1 | Input sample strobe, one cycle |
| delay_i | input | ADDR_W | Delay in samples, captured after reset |
| rd_tick_i | input | 1 | Read-rate tick, one cycle, requests one output sample |
| smp_o | output | DATA_W | Delayed output sample |
| smp_valid_o | output | 1 | Output sample strobe |
| sram_addr_o | output | ADDR_W | Shared SRAM address |
| sram_wdata_o | output | DATA_W | SRAM write data |
| sram_rdata_i | input | DATA_W | SRAM read data (asynchronous read) |
| sram_ce_o | output | 1 | SRAM chip enable for the current slot |
| sram_we_o | output | 1 | SRAM write enable |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
A strobe is registered on the next edge. The matching slot then comes one or two edges later, depending on the phase, so the SRAM write appears two or three cycles after the strobe is driven. The output pulse follows its read slot by one further edge. The bench therefore scans a fixed window of five cycles after each read tick, samples at falling edges, and requires exactly one output pulse carrying the value predicted by a software queue model. A falling-edge monitor compares every SRAM write against a model address counter and the queued data, and checks that writes and reads each keep to one cycle in two.

// File: rtl/audio_delay_pkg.sv
package audio_delay_pkg;
  typedef enum logic {SLOT_WR = 1'b0, SLOT_RD = 1'b1} slot_e;
endpackage

// File: rtl/audio_delay_slot_seq.sv
module audio_delay_slot_seq
  import audio_delay_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_req_i,
  input  logic  rd_req_i,
  output slot_e slot_o,
  output logic  wr_fire_o,
  output logic  rd_fire_o
);
  slot_e slot_q;
  logic  wr_pend_q, rd_pend_q;

  assign slot_o    = slot_q;
  assign wr_fire_o = (slot_q == SLOT_WR) && wr_pend_q;
  assign rd_fire_o = (slot_q == SLOT_RD) && rd_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q    <= SLOT_WR;
      wr_pend_q <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      slot_q    <= (slot_q == SLOT_WR) ? SLOT_RD : SLOT_WR;
      wr_pend_q <= wr_req_i | (wr_pend_q & ~wr_fire_o);
      rd_pend_q <= rd_req_i | (rd_pend_q & ~rd_fire_o);
    end
  end
endmodule

// File: rtl/audio_delay_ptr_ctr.sv
module audio_delay_ptr_ctr #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] ptr_q;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (inc_i) ptr_q <= ptr_q + 1'b1;
  end
endmodule

// File: rtl/audio_delay_gate.sv
module audio_delay_gate #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] delay_i,
  input  logic         step_i,
  output logic         hold_o
);
  logic         armed_q;
  logic [W-1:0] cnt_q;

  assign hold_o = !armed_q || (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      cnt_q   <= delay_i;
    end else if (step_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/audio_delay_ctrl.sv
module audio_delay_ctrl
  import audio_delay_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              smp_valid_i,
  input  logic [ADDR_W-1:0] delay_i,
  input  logic              rd_tick_i,
  output logic [DATA_W-1:0] smp_o,
  output logic              smp_valid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_wdata_o,
  input  logic [DATA_W-1:0] sram_rdata_i,
  output logic              sram_ce_o,
  output logic              sram_we_o,
  output logic              overrun_o
);
  localparam int unsigned PW = ADDR_W + 1;  // extra bit separates full from empty

  slot_e             slot;
  logic              rd_slot;
  logic              wr_fire, rd_fire, hold;
  logic [PW-1:0]     wr_ptr, rd_ptr, level;
  logic              full, empty, rd_ok, rd_inc, lap;
  logic [DATA_W-1:0] wdata_q, out_q;
  logic              out_vld_q, ovr_q;

  audio_delay_slot_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (smp_valid_i),
    .rd_req_i  (rd_tick_i),
    .slot_o    (slot),
    .wr_fire_o (wr_fire),
    .rd_fire_o (rd_fire)
  );

  audio_delay_gate #(.W(ADDR_W)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .delay_i (delay_i),
    .step_i  (wr_fire),
    .hold_o  (hold)
  );

  audio_delay_ptr_ctr #(.W(PW)) u_wr_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (wr_fire),
    .ptr_o  (wr_ptr)
  );

  audio_delay_ptr_ctr #(.W(PW)) u_rd_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (rd_inc),
    .ptr_o  (rd_ptr)
  );

  assign rd_slot = (slot == SLOT_RD);
  assign level   = wr_ptr - rd_ptr;
  assign full    = level[ADDR_W];
  assign empty   = (level == '0);
  assign lap     = wr_fire && full;
  assign rd_ok   = rd_fire && !hold && !empty;
  assign rd_inc  = rd_ok || lap;  // lap drops the oldest entry

  assign sram_addr_o  = rd_slot ? rd_ptr[ADDR_W-1:0] : wr_ptr[ADDR_W-1:0];
  assign sram_wdata_o = wdata_q;
  assign sram_we_o    = wr_fire;
  assign sram_ce_o    = wr_fire || rd_ok;
  assign smp_o        = out_q;
  assign smp_valid_o  = out_vld_q;
  assign overrun_o    = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q   <= '0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (smp_valid_i) wdata_q <= smp_i;
      out_vld_q <= rd_fire;
      if (rd_fire) out_q <= rd_ok ? sram_rdata_i : '0;
      if (lap) ovr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/audio_delay_ctrl_chk.sv
module audio_delay_ctrl_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sram_we_o,
  input logic              sram_ce_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              smp_valid_o,
  input logic              overrun_o,
  input logic              rd_slot
);
  logic [ADDR_W-1:0] exp_wa_q;
  logic              rd_acc;

  assign rd_acc = sram_ce_o && !sram_we_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        exp_wa_q <= '0;
    else if (sram_we_o) exp_wa_q <= exp_wa_q + 1'b1;
  end

  assert_we_alternate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |=> !sram_we_o);
  assert_rd_alternate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> !rd_acc);
  assert_we_in_wr_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> !rd_slot);
  assert_write_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> sram_addr_o == exp_wa_q);
  assert_overrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o);
  assert_valid_after_rd_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(rd_slot));
endmodule

bind audio_delay_ctrl audio_delay_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sram_we_o   (sram_we_o),
  .sram_ce_o   (sram_ce_o),
  .sram_addr_o (sram_addr_o),
  .smp_valid_o (smp_valid_o),
  .overrun_o   (overrun_o),
  .rd_slot     (rd_slot)
);

// File: tb/audio_delay_ctrl_tb_top.sv
module audio_delay_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] smp_in = '0;
  logic          smp_vld_in = 1'b0;
  logic [AW-1:0] delay = '0;
  logic          rd_tick = 1'b0;
  logic [DW-1:0] smp_out, wdata, rdata;
  logic          smp_vld_out, ce, we, ovr;
  logic [AW-1:0] addr;
  logic [DW-1:0] mem [DEPTH];

  int total = 0;
  int bad = 0;

  // model state
  logic [DW-1:0] q [256];
  int q_head = 0, q_tail = 0, w_count = 0, m_delay = 0;
  int exp_wa = 0;
  logic m_ovr = 1'b0;
  logic [DW-1:0] wq [256];
  int wq_head = 0, wq_tail = 0;
  logic prev_we = 1'b0, prev_rd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_delay_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .smp_i        (smp_in),
    .smp_valid_i  (smp_vld_in),
    .delay_i      (delay),
    .rd_tick_i    (rd_tick),
    .smp_o        (smp_out),
    .smp_valid_o  (smp_vld_out),
    .sram_addr_o  (addr),
    .sram_wdata_o (wdata),
    .sram_rdata_i (rdata),
    .sram_ce_o    (ce),
    .sram_we_o    (we),
    .overrun_o    (ovr)
  );

  // asynchronous-read SRAM model
  assign rdata = mem[addr];
  always @(posedge clk) if (ce && we) mem[addr] <= wdata;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bus monitor: write address/data and slot alternation
  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin
        check(addr == AW'(exp_wa), "R3 write addr", addr, exp_wa);
        check(wq_tail > wq_head && wdata == wq[wq_head], "R3 write data", wdata,
              wq[wq_head]);
        check(!prev_we, "R2 write alternation", prev_we, 0);
        wq_head++;
        exp_wa++;
      end
      if (ce && !we) check(!prev_rd, "R2 read alternation", prev_rd, 0);
      prev_we = we;
      prev_rd = ce && !we;
    end else begin
      prev_we = 1'b0;
      prev_rd = 1'b0;
    end
  end

  task automatic do_reset(input int dly);
    @(negedge clk);
    rst_n = 1'b0;
    delay = AW'(dly);
    smp_vld_in = 1'b0;
    rd_tick = 1'b0;
    repeat (2) @(negedge clk);
    check(smp_vld_out == 0 && ovr == 0 && we == 0, "R1 during reset",
          {smp_vld_out, ovr, we}, 0);
    q_head = 0; q_tail = 0; w_count = 0; m_delay = dly; m_ovr = 1'b0;
    exp_wa = 0; wq_head = 0; wq_tail = 0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(smp_vld_out == 0 && ovr == 0 && we == 0, "R1 after reset",
          {smp_vld_out, ovr, we}, 0);
  endtask

  task automatic push(input logic [DW-1:0] d);
    if (q_tail - q_head == DEPTH) begin
      q_head++;
      m_ovr = 1'b1;
    end
    q[q_tail] = d; q_tail++;
    wq[wq_tail] = d; wq_tail++;
    w_count++;
    smp_in = d;
    smp_vld_in = 1'b1;
    @(negedge clk);
    smp_vld_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pull(input string tag);
    logic [DW-1:0] exp_v;
    logic [DW-1:0] got;
    int pulses;
    if (w_count < m_delay || q_tail == q_head) exp_v = '0;
    else begin
      exp_v = q[q_head];
      q_head++;
    end
    rd_tick = 1'b1;
    @(negedge clk);
    rd_tick = 1'b0;
    pulses = 0;
    got = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (smp_vld_out) begin
        pulses++;
        got = smp_out;
      end
    end
    check(pulses == 1, {tag, " R8 pulse count"}, pulses, 1);
    check(got == exp_v, tag, got, exp_v);
  endtask

  task automatic t_reset();
    do_reset(3);
  endtask

  task automatic t_delay_hold();
    do_reset(3);
    push(16'h0100);
    push(16'h0101);
    pull("R4 held read gives zero");
    push(16'h0102);
    pull("R4 first read after delay");
    pull("R5 second read");
    pull("R5 third read");
    pull("R6 underrun gives zero");
    push(16'h0103);
    pull("R6 pointer unchanged after underrun");
  endtask

  task automatic t_rate();
    do_reset(0);
    pull("R6 empty read zero");
    for (int i = 0; i < 5; i++) push(DW'(16'h0200 + i));
    pull("R9 fast write slow read a");
    pull("R9 fast write slow read b");
    push(16'h0210);
    push(16'h0211);
    for (int i = 0; i < 5; i++) pull("R9 read burst order");
    pull("R6 drained zero");
  endtask

  task automatic t_overrun();
    do_reset(0);
    for (int i = 0; i < DEPTH; i++) push(DW'(16'h0300 + i));
    check(ovr == 1'b0, "R7 no overrun at exactly full", ovr, 0);
    push(16'h03ff);
    check(ovr == 1'b1, "R7 overrun set on lap", ovr, 1);
    pull("R7 oldest discarded");
    pull("R7 next in order");
    check(ovr == 1'b1, "R7 overrun sticky", ovr, 1);
    for (int i = 0; i < DEPTH - 2; i++) pull("R3 wrapped contents");
    pull("R6 empty after wrap");
    check(ovr == m_ovr, "R7 flag vs model", ovr, m_ovr);
    do_reset(0);
    check(ovr == 1'b0, "R1 overrun cleared by reset", ovr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_delay_hold();
    t_rate();
    t_overrun();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule